// File: doc/BRIEF.md
# Mezzanine Slot Address Decoder Bridge

This bridge connects a host local bus to four mezzanine module slots. The host chooses one of four windows with a window code: a configuration byte block, a 1 KiB register window, a 32 MiB halfword memory window and a 16 MiB byte memory window. The bridge splits the address of each access into a slot number, a target space (I/O, identification, interrupt or memory) and an offset. It then drives a request to that slot and holds it until the slot acknowledges.

Two of the windows can be switched to big-endian mode by bits in the configuration block. In that mode a byte access reaches the opposite byte address, and a halfword access has its two bytes exchanged in both directions. Some accesses never reach a slot: those aimed at a slot whose present input is low, halfword accesses to the byte window, and every configuration access. The bridge completes these itself.

Top module: `mezz_slot_bridge`

## Requirements
- R1: After reset `req_ready` is low, `slot_sel` is zero, and all three endian bits read as 0 (little-endian).
- R2: Register window (code 1): the slot is address bits [9:8] and the space field is bits [7:6]. Field value 2 gives identification space (`slot_space` 1) with offset bits [5:0]. Field value 3 gives interrupt space (`slot_space` 2) with offset bits [5:0]. Field values 0 and 1 give I/O space (`slot_space` 0) with offset bits [6:0].
- R3: Halfword memory window (code 2): the slot is bits [24:23] and the offset is bits [22:0], with `slot_space` 3. Byte and halfword accesses are both accepted.
- R4: Byte memory window (code 3): the slot is bits [23:22] and the offset is bits [21:0], with `slot_space` 3. A halfword access there raises no slot request, reads 0 and drops its write.
- R5: In big-endian mode, a byte access to the register or halfword memory window has offset bit 0 inverted. The byte memory window is never corrected.
- R6: In big-endian mode, a halfword access to the register or halfword memory window has the two bytes of write data and of read data swapped.
- R7: Configuration window (code 0, byte index = address bits [6:0]): bit 0 of bytes 0x2B, 0x2F and 0x33 is writable. 0x2F sets big-endian mode for the register window, 0x33 sets it for the halfword memory window, and 0x2B drives no window. Every other byte below 88 reads the constant ((index*37+11) mod 256). Bytes from 88 upward read 0. Writes elsewhere have no effect. Reads return the byte in `rsp_rdata[7:0]`.
- R8: An access to a slot whose `slot_present` bit is low raises no request, reads 0 and drops its write. It completes with `req_ready` one cycle after acceptance, as do all configuration accesses.
- R9: Only one access is outstanding at a time. `slot_sel` is one-hot and is held until that slot acknowledges. `req_ready` is high for exactly one cycle, in the cycle after the acknowledge.
- R10: An acknowledge from a slot other than the selected one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access request, held until `req_ready` |
| req_win | input | 2 | Window code: 0 config, 1 register, 2 halfword memory, 3 byte memory |
| req_we | input | 1 | 1 = write |
| req_half | input | 1 | 1 = halfword, 0 = byte (in bits [7:0]) |
| req_addr | input | 25 | Window-relative byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid while `req_ready` is high |
| slot_present | input | 4 | Module installed, one bit per slot |
| slot_sel | output | 4 | One-hot slot request |
| slot_we | output | 1 | Slot write enable |
| slot_byte | output | 1 | Slot access is a byte |
| slot_space | output | 2 | 0 I/O, 1 identification, 2 interrupt, 3 memory |
| slot_addr | output | 23 | Offset inside the target space |
| slot_wdata | output | 16 | Lane-corrected write data |
| slot_ack | input | 4 | Per-slot acknowledge |
| slot_rdata | input | 64 | Per-slot read data, slot n in bits [16n+15:16n] |

## Verification
Most internal faults show at the slot port in the cycle after acceptance. A wrong endian bit or a wrong decode moves `slot_addr`, `slot_space` or the one-hot `slot_sel`, or leaves `slot_wdata` unswapped, before any acknowledge arrives. Read-lane faults show only when `req_ready` rises. A stuck state machine shows as `req_ready` that never comes, or that comes one cycle after acceptance on a path that should have waited for the slot. An endian bit that survives reset only becomes visible when the configuration byte is read back or when the next access to the affected window is made.

// File: rtl/mezz_pkg.sv
package mezz_pkg;
  localparam int NSLOT       = 4;
  localparam int SLOT_W      = $clog2(NSLOT);
  localparam int DW          = 16;
  localparam int AW          = 25;
  localparam int OFF_W       = 23;
  localparam int CFG_IW      = 7;
  localparam int CFG_LEN     = 88;
  localparam int N_ENDIAN    = 3;
  localparam logic [CFG_IW-1:0] ENDIAN_BASE = 7'h2B;
  localparam int ENDIAN_STEP = 4;

  typedef enum logic [1:0] {WIN_CFG = 2'd0, WIN_REG = 2'd1, WIN_M16 = 2'd2, WIN_M8 = 2'd3} win_e;
  typedef enum logic [1:0] {SP_IO = 2'd0, SP_ID = 2'd1, SP_INT = 2'd2, SP_MEM = 2'd3} space_e;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    space_e            space;
    logic [OFF_W-1:0]  off;
    logic              to_slot;
  } route_t;

  function automatic logic is_endian_byte(input logic [CFG_IW-1:0] idx);
    logic hit;
    hit = 1'b0;
    for (int g = 0; g < N_ENDIAN; g++)
      if (idx == ENDIAN_BASE + CFG_IW'(ENDIAN_STEP * g)) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic [7:0] cfg_const(input logic [CFG_IW-1:0] idx);
    logic [31:0] t;
    logic [7:0]  v;
    t = 32'(int'(idx) * 37 + 11);
    v = (int'(idx) < CFG_LEN) ? t[7:0] : 8'h00;
    if (is_endian_byte(idx)) v[0] = 1'b0;
    return v;
  endfunction

  function automatic logic [DW-1:0] lane_fix(input logic [DW-1:0] d, input logic half,
                                            input logic swap);
    if (!half) return {8'h00, d[7:0]};
    return swap ? {d[7:0], d[15:8]} : d;
  endfunction
endpackage

// File: rtl/mezz_cfg_regs.sv
module mezz_cfg_regs
  import mezz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_IW-1:0] idx,
  input  logic              wbit,
  output logic [N_ENDIAN-1:0] be,
  output logic [7:0]        rd_byte
);
  for (genvar g = 0; g < N_ENDIAN; g++) begin : g_bit
    localparam logic [CFG_IW-1:0] LOC = ENDIAN_BASE + CFG_IW'(ENDIAN_STEP * g);
    always_ff @(posedge clk) begin
      if (!rst_n)                  be[g] <= 1'b0;
      else if (wr_en && idx == LOC) be[g] <= wbit;
    end
  end

  always_comb begin
    rd_byte = cfg_const(idx);
    for (int g = 0; g < N_ENDIAN; g++)
      if (idx == ENDIAN_BASE + CFG_IW'(ENDIAN_STEP * g)) rd_byte[0] = be[g];
  end

  // R7: endian bits only move on a configuration write
  a_r7_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(be));
endmodule

// File: rtl/mezz_win_decode.sv
module mezz_win_decode
  import mezz_pkg::*;
(
  input  win_e             win,
  input  logic [AW-1:0]    addr,
  input  logic             half,
  input  logic             be_reg,
  input  logic             be_m16,
  input  logic [NSLOT-1:0] present,
  output route_t           rt,
  output logic             swap
);
  logic [AW-1:0] a;
  logic          legal;

  always_comb begin
    a      = addr;
    legal  = 1'b1;
    rt     = '0;
    swap   = 1'b0;
    unique case (win)
      WIN_REG: begin
        if (be_reg && !half) a[0] = ~a[0];
        swap    = be_reg && half;
        rt.slot = a[9:8];
        unique case (a[7:6])
          2'd2:    begin rt.space = SP_ID;  rt.off = {{(OFF_W-6){1'b0}}, a[5:0]}; end
          2'd3:    begin rt.space = SP_INT; rt.off = {{(OFF_W-6){1'b0}}, a[5:0]}; end
          default: begin rt.space = SP_IO;  rt.off = {{(OFF_W-7){1'b0}}, a[6:0]}; end
        endcase
      end
      WIN_M16: begin
        if (be_m16 && !half) a[0] = ~a[0];
        swap     = be_m16 && half;
        rt.slot  = a[24:23];
        rt.space = SP_MEM;
        rt.off   = a[OFF_W-1:0];
      end
      WIN_M8: begin
        rt.slot  = a[23:22];
        rt.space = SP_MEM;
        rt.off   = {1'b0, a[21:0]};
        legal    = !half;
      end
      default: legal = 1'b0;
    endcase
    rt.to_slot = legal && present[rt.slot];
  end
endmodule

// File: rtl/mezz_slot_bridge.sv
module mezz_slot_bridge
  import mezz_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_win,
  input  logic                req_we,
  input  logic                req_half,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                req_ready,
  output logic [DW-1:0]       rsp_rdata,
  input  logic [NSLOT-1:0]    slot_present,
  output logic [NSLOT-1:0]    slot_sel,
  output logic                slot_we,
  output logic                slot_byte,
  output logic [1:0]          slot_space,
  output logic [OFF_W-1:0]    slot_addr,
  output logic [DW-1:0]       slot_wdata,
  input  logic [NSLOT-1:0]    slot_ack,
  input  logic [NSLOT*DW-1:0] slot_rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} st_e;
  st_e state;

  win_e                win;
  route_t              rt;
  logic                swap_now, swap_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [N_ENDIAN-1:0] be;
  logic [7:0]          cfg_byte;
  logic                accept, cfg_wr, ack_hit;
  logic [DW-1:0]       lane_rd;

  assign win      = win_e'(req_win);
  assign accept   = (state == ST_IDLE) && req_valid;
  assign cfg_wr   = accept && (win == WIN_CFG) && req_we;
  assign ack_hit  = (state == ST_WAIT) && slot_ack[slot_q];
  assign lane_rd  = slot_rdata[slot_q*DW +: DW];
  assign req_ready = (state == ST_DONE);

  mezz_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .idx(req_addr[CFG_IW-1:0]),
    .wbit(req_wdata[0]), .be(be), .rd_byte(cfg_byte)
  );

  mezz_win_decode u_dec (
    .win(win), .addr(req_addr), .half(req_half), .be_reg(be[1]), .be_m16(be[2]),
    .present(slot_present), .rt(rt), .swap(swap_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      slot_sel   <= '0;
      slot_we    <= 1'b0;
      slot_byte  <= 1'b0;
      slot_space <= '0;
      slot_addr  <= '0;
      slot_wdata <= '0;
      slot_q     <= '0;
      swap_q     <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          if (rt.to_slot) begin
            slot_sel   <= NSLOT'(1) << rt.slot;
            slot_we    <= req_we;
            slot_byte  <= !req_half;
            slot_space <= rt.space;
            slot_addr  <= rt.off;
            slot_wdata <= lane_fix(req_wdata, req_half, swap_now);
            slot_q     <= rt.slot;
            swap_q     <= swap_now;
            state      <= ST_WAIT;
          end else begin
            rsp_rdata <= (win == WIN_CFG && !req_we) ? {8'h00, cfg_byte} : '0;
            state     <= ST_DONE;
          end
        end
        ST_WAIT: if (ack_hit) begin
          rsp_rdata <= lane_fix(lane_rd, !slot_byte, swap_q);
          slot_sel  <= '0;
          state     <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: at most one slot requested
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(slot_sel));
  // R8: no request to an empty slot
  a_r8_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_sel & ~slot_present) == '0);
  // R9: completion is a single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n) req_ready |=> !req_ready);
  // R9, R10: request held until its own slot acknowledges
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_sel != '0) && ((slot_sel & slot_ack) == '0)) |=> $stable(slot_sel));
  // R9: a slot-path completion follows an acknowledge from that slot
  a_r9_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(slot_sel != '0)) |-> $past((slot_sel & slot_ack) != '0));
  // R4: halfword into the byte window never reaches a slot
  a_r4_m8_half: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && win == WIN_M8 && req_half) |=> (slot_sel == '0));
endmodule

// File: tb/mezz_slot_bridge_bench.sv
module mezz_slot_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_win = '0;
  logic        req_we = 1'b0, req_half = 1'b0;
  logic [24:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic [15:0] rsp_rdata;
  logic [3:0]  slot_present = 4'b1011;
  logic [3:0]  slot_sel;
  logic        slot_we, slot_byte;
  logic [1:0]  slot_space;
  logic [22:0] slot_addr;
  logic [15:0] slot_wdata;
  logic [3:0]  slot_ack = '0;
  logic [63:0] slot_rdata = '0;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mezz_slot_bridge u_mezz_slot_bridge (.*);

  typedef struct packed {
    logic [1:0]  w;   logic we;  logic half; logic [24:0] a;
    logic [15:0] wd;  logic [15:0] sd;
    logic hit; logic [1:0] slot; logic [1:0] sp; logic [22:0] off;
    logic [15:0] dat; logic [3:0] tag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd1,1'b0,1'b1,25'h0000125,16'h0000,16'h1234,1'b1,2'd1,2'd0,23'h25,16'h1234,4'd2},    // R2 IO
    '{2'd1,1'b0,1'b0,25'h000005A,16'h0000,16'hBEEF,1'b1,2'd0,2'd0,23'h5A,16'h00EF,4'd2},    // R2 IO sel=1
    '{2'd1,1'b1,1'b1,25'h00003AB,16'hCAFE,16'h0000,1'b1,2'd3,2'd1,23'h2B,16'hCAFE,4'd2},    // R2 ID
    '{2'd1,1'b0,1'b0,25'h00000C7,16'h0000,16'h5577,1'b1,2'd0,2'd2,23'h07,16'h0077,4'd2},    // R2 INT
    '{2'd2,1'b0,1'b1,25'h192345E,16'h0000,16'hA55A,1'b1,2'd3,2'd3,23'h12345E,16'hA55A,4'd3},// R3
    '{2'd2,1'b1,1'b0,25'h0800101,16'h44AB,16'h0000,1'b1,2'd1,2'd3,23'h000101,16'h00AB,4'd3},// R3
    '{2'd3,1'b0,1'b0,25'h0C2ABCD,16'h0000,16'h1199,1'b1,2'd3,2'd3,23'h02ABCD,16'h0099,4'd4},// R4
    '{2'd3,1'b0,1'b1,25'h0400010,16'h0000,16'hFFFF,1'b0,2'd0,2'd0,23'h0,16'h0000,4'd4},     // R4 half
    '{2'd1,1'b0,1'b1,25'h0000210,16'h0000,16'hFFFF,1'b0,2'd0,2'd0,23'h0,16'h0000,4'd8},     // R8 read
    '{2'd2,1'b1,1'b1,25'h1000004,16'h1234,16'h0000,1'b0,2'd0,2'd0,23'h0,16'h0000,4'd8},     // R8 write
    '{2'd0,1'b0,1'b0,25'h0000005,16'h0000,16'h0000,1'b0,2'd0,2'd0,23'h0,16'h00C4,4'd7},     // R7 const
    '{2'd0,1'b0,1'b0,25'h0000060,16'h0000,16'h0000,1'b0,2'd0,2'd0,23'h0,16'h0000,4'd7}      // R7 beyond
  };

  logic        cap_seen, cap_we, cap_byte;
  logic [3:0]  cap_sel;
  logic [1:0]  cap_sp;
  logic [22:0] cap_off;
  logic [15:0] cap_wd, got_rd;
  int          got_n;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg_model(input int i);
    int v;
    v = (i >= 88) ? 0 : ((i * 37 + 11) % 256);
    if (i == 43 || i == 47 || i == 51) v = v & 254;
    return 8'(v);
  endfunction

  task automatic xfer(input logic [1:0] w, input logic we, input logic half,
                      input logic [24:0] a, input logic [15:0] wd, input logic [15:0] sd,
                      input logic stray);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_win = w; req_we = we; req_half = half; req_addr = a; req_wdata = wd;
    cap_seen = 1'b0; n = 0;
    while (!req_ready && n < 30) begin
      @(negedge clk); n++;
      if (slot_sel != '0 && !cap_seen) begin
        cap_seen = 1'b1; cap_sel = slot_sel; cap_sp = slot_space; cap_off = slot_addr;
        cap_wd = slot_wdata; cap_we = slot_we; cap_byte = slot_byte;
        slot_rdata = {4{16'hDEAD}};
        for (int s = 0; s < 4; s++) if (slot_sel[s]) slot_rdata[s*16 +: 16] = sd;
        if (stray) slot_ack = slot_present & ~slot_sel;
        @(negedge clk); n++;
        slot_ack = '0;
        if (stray) begin
          chk("R10 stray ack ignored (ready)", {31'b0, req_ready}, 0);
          chk("R10 stray ack ignored (sel held)", {28'b0, slot_sel}, {28'b0, cap_sel});
        end
        @(negedge clk); n++;
        slot_ack = cap_sel;
      end
    end
    got_rd = rsp_rdata; got_n = n;
    slot_ack = '0;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready low", {31'b0, req_ready}, 0);
    chk("R1 sel zero", {28'b0, slot_sel}, 0);
    xfer(2'd0, 1'b0, 1'b0, 25'h2B, 0, 0, 0); chk("R1 endian 0x2B", got_rd, cfg_model(43));
    xfer(2'd0, 1'b0, 1'b0, 25'h2F, 0, 0, 0); chk("R1 endian 0x2F", got_rd, cfg_model(47));
    xfer(2'd0, 1'b0, 1'b0, 25'h33, 0, 0, 0); chk("R1 endian 0x33", got_rd, cfg_model(51));

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      t = $sformatf("R%0d vec%0d", v.tag, i);
      xfer(v.w, v.we, v.half, v.a, v.wd, v.sd, 0);
      chk({t, " strobe"}, {31'b0, cap_seen}, {31'b0, v.hit});
      chk({t, " R9/R8 cycles"}, got_n, v.hit ? 4 : 1);
      if (v.hit) begin
        chk({t, " slot"}, {28'b0, cap_sel}, 32'(4'b1 << v.slot));
        chk({t, " space"}, cap_sp, v.sp);
        chk({t, " offset"}, cap_off, v.off);
        chk({t, " byte"}, {31'b0, cap_byte}, {31'b0, ~v.half});
        chk({t, " we"}, {31'b0, cap_we}, {31'b0, v.we});
        if (v.we) chk({t, " wdata"}, cap_wd, v.dat);
      end
      if (!v.we) chk({t, " rdata"}, got_rd, v.dat);
    end

    // R7 writes: non-endian byte ignored, 0x2B bit stored without effect on windows
    xfer(2'd0, 1'b1, 1'b0, 25'h05, 16'h00FF, 0, 0);
    xfer(2'd0, 1'b0, 1'b0, 25'h05, 0, 0, 0); chk("R7 const write ignored", got_rd, cfg_model(5));
    xfer(2'd0, 1'b1, 1'b0, 25'h2B, 16'h0001, 0, 0);
    xfer(2'd0, 1'b0, 1'b0, 25'h2B, 0, 0, 0); chk("R7 0x2B readback", got_rd, cfg_model(43) | 1);
    xfer(2'd1, 1'b0, 1'b1, 25'h125, 0, 16'h1234, 0); chk("R7 0x2B no swap", got_rd, 16'h1234);

    // R5/R6 register window big-endian
    xfer(2'd0, 1'b1, 1'b0, 25'h2F, 16'h0001, 0, 0);
    xfer(2'd0, 1'b0, 1'b0, 25'h2F, 0, 0, 0); chk("R7 0x2F readback", got_rd, cfg_model(47) | 1);
    xfer(2'd1, 1'b0, 1'b0, 25'h125, 0, 16'h1234, 0); chk("R5 reg byte flip", cap_off, 23'h24);
    xfer(2'd1, 1'b0, 1'b1, 25'h125, 0, 16'h1234, 0); chk("R6 reg half read swap", got_rd, 16'h3412);
    xfer(2'd1, 1'b1, 1'b1, 25'h3AB, 16'hCAFE, 0, 0); chk("R6 reg half write swap", cap_wd, 16'hFECA);
    xfer(2'd2, 1'b0, 1'b1, 25'h192345E, 0, 16'hA55A, 0); chk("R6 m16 untouched by 0x2F", got_rd, 16'hA55A);

    // R5/R6 halfword memory window big-endian; byte window never corrected
    xfer(2'd0, 1'b1, 1'b0, 25'h33, 16'h0001, 0, 0);
    xfer(2'd2, 1'b0, 1'b0, 25'h0800101, 0, 16'h0000, 0); chk("R5 m16 byte flip", cap_off, 23'h000100);
    xfer(2'd2, 1'b1, 1'b1, 25'h0800100, 16'h1122, 0, 0); chk("R6 m16 half write swap", cap_wd, 16'h2211);
    xfer(2'd2, 1'b0, 1'b1, 25'h0800100, 0, 16'h3344, 0); chk("R6 m16 half read swap", got_rd, 16'h4433);
    xfer(2'd3, 1'b0, 1'b0, 25'h0C2ABCD, 0, 16'h1199, 0); chk("R5 m8 no flip", cap_off, 23'h02ABCD);

    // R10 stray acknowledge from another slot
    xfer(2'd1, 1'b0, 1'b1, 25'h125, 0, 16'h5A5A, 1);
    chk("R10 rdata after stray", got_rd, 16'h3412 ^ 16'h3412 ^ 16'h5A5A);
    chk("R10 cycles", got_n, 4);

    // R1 reset clears endian bits
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    xfer(2'd0, 1'b0, 1'b0, 25'h2F, 0, 0, 0); chk("R1 0x2F cleared", got_rd, cfg_model(47));
    xfer(2'd1, 1'b0, 1'b1, 25'h125, 0, 16'h1234, 0); chk("R1 little-endian again", got_rd, 16'h1234);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule